// File: doc/BRIEF.md
# Gap-One LDPC Parity Solver

This block produces the parity of a rate-2/3 quasi-cyclic LDPC codeword whose base matrix has 8 block rows, 24 block columns and 16 information columns, lifted by 64-bit circulants. The base matrix is split into an upper part of seven block rows and a single lower block row, the gap. The upper part has a double-diagonal triangular block `T`. The lower row's correction term works out to the identity over GF(2). Because of that, the parity needs no dense generator matrix and no matrix inversion. It comes from XOR running sums and circulant rotations.

An upstream stage supplies two partial products of the information word. One is the upper partial product: seven 64-bit segments, the information bits times the upper information block. The other is the lower partial product: one 64-bit segment, the information bits times the lower information row. Along with these, upstream gives the circulant shifts of the lower row's triangular part (`e_shift_i`) and of the upper part's gap column (`b_shift_i`).

A start pulse captures all inputs. A fixed schedule of six one-cycle steps then runs:

1. Running XOR (forward substitution) of the upper product.
2. Circulant product with the lower row.
3. XOR with the lower partial product, which gives the 64-bit short parity.
4. Circulant product with the gap column.
5. XOR with the upper product.
6. A second running XOR, which gives the 448-bit long parity.

A one-cycle done pulse marks the result. The results are held until the next frame completes.

Top module: `ldpc_gap_solver`

## Requirements
- R1: Segment `j` (j = 0..6) of a 448-bit bus occupies bits `[64j+63:64j]`, and the shift field of block position `j` occupies bits `[7j+6:7j]` of its 21+28 = 49-bit shift bus.
- R2: A circulant product with shift `q` maps segment `x` to `y` with `y[i] = x[(i+q) mod 64]`. Any shift of 64 or more (127 is the canonical code) denotes an all-zero block and yields zero.
- R3: The short parity equals the lower partial product XOR the XOR over `j` of `rot(e_j, s_j)`, where `s_j` is the XOR of upper-product segments 0..j.
- R4: Long-parity segment `i` equals the XOR over `k <= i` of (upper segment `k` XOR `rot(b_k, short parity)`).
- R5: For every upper block row `i`, long segment `i` XOR long segment `i-1` (absent for `i = 0`) XOR `rot(b_i, short parity)` equals upper-product segment `i`. In other words, every upper check row sums to zero.
- R6: `done_o` is high exactly in the sixth cycle after the clock edge that accepted `start_i`, and at no other time.
- R7: `done_o` is a single-cycle pulse.
- R8: `p_short_o` and `p_long_o` change only at the edge that raises `done_o`, and hold their values otherwise.
- R9: `start_i` is ignored while a frame is in flight. The running frame finishes on schedule with the inputs it captured.
- R10: After reset, both parity outputs are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the inputs and launches a frame when idle |
| up_prod_i | input | 448 | Upper partial product, seven 64-bit segments |
| low_prod_i | input | 64 | Lower partial product |
| e_shift_i | input | 49 | Lower-row shifts over the triangular columns, 7 bits each |
| b_shift_i | input | 49 | Gap-column shifts of the upper rows, 7 bits each |
| p_short_o | output | 64 | Short (gap) parity |
| p_long_o | output | 448 | Long parity, seven 64-bit segments |
| done_o | output | 1 | One-cycle pulse when the parity is valid |

## Verification
The checker watches the schedule on every cycle. It covers done latency counted from the accepted start (with starts during a frame ignored), the single-cycle done pulse, and output hold between frames. It also checks, at done, that each long-parity segment is the running XOR of the internal combined vector. The arithmetic of the circulant rotations is shown only by the bench's frames. That covers the short parity, the long parity, zero-block shift codes, the shift boundaries 63 and 64, and whether the upper check rows really sum to zero.

// File: rtl/ldpc_gap_pkg.sv
package ldpc_gap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FWD1  = 3'd1,
    ST_EMUL  = 3'd2,
    ST_SHORT = 3'd3,
    ST_BMUL  = 3'd4,
    ST_COMB  = 3'd5,
    ST_FWD2  = 3'd6
  } step_e;

  localparam int unsigned STEP_COUNT = 6;
endpackage

// File: rtl/ldpc_circ_rot.sv
module ldpc_circ_rot #(
  parameter int unsigned Z   = 64,
  parameter int unsigned SHW = 7
) (
  input  logic [Z-1:0]   seg_i,
  input  logic [SHW-1:0] shift_i,
  output logic [Z-1:0]   seg_o
);
  logic [2*Z-1:0] dbl;
  logic [2*Z-1:0] shf;
  logic           zero_blk;

  always_comb begin
    dbl      = {seg_i, seg_i};
    shf      = dbl >> shift_i;
    // shift codes past the lifting size mark an empty block
    zero_blk = (32'(shift_i) >= Z);
    seg_o    = zero_blk ? '0 : shf[Z-1:0];
  end
endmodule

// File: rtl/ldpc_prefix_xor.sv
module ldpc_prefix_xor #(
  parameter int unsigned Z    = 64,
  parameter int unsigned NSEG = 7
) (
  input  logic [NSEG*Z-1:0] vec_i,
  output logic [NSEG*Z-1:0] acc_o
);
  logic [Z-1:0] run;

  // T^-1 on a double-diagonal block: running XOR, all segments in parallel
  always_comb begin
    run   = '0;
    acc_o = '0;
    for (int s = 0; s < NSEG; s++) begin
      run            = run ^ vec_i[s*Z +: Z];
      acc_o[s*Z +: Z] = run;
    end
  end
endmodule

// File: rtl/ldpc_gap_solver.sv
module ldpc_gap_solver
  import ldpc_gap_pkg::*;
#(
  parameter int unsigned Z    = 64,
  parameter int unsigned NSEG = 7,
  parameter int unsigned SHW  = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NSEG*Z-1:0]    up_prod_i,
  input  logic [Z-1:0]         low_prod_i,
  input  logic [NSEG*SHW-1:0]  e_shift_i,
  input  logic [NSEG*SHW-1:0]  b_shift_i,
  output logic [Z-1:0]         p_short_o,
  output logic [NSEG*Z-1:0]    p_long_o,
  output logic                 done_o
);
  localparam int unsigned W  = NSEG * Z;
  localparam int unsigned SW = NSEG * SHW;

  step_e        step_q, step_d;
  logic [W-1:0]  up_q;
  logic [Z-1:0]  low_q;
  logic [SW-1:0] e_q, b_q;
  logic [W-1:0]  work_q;
  logic [Z-1:0]  ps_q;
  logic [Z-1:0]  p_short_q;
  logic [W-1:0]  p_long_q;
  logic          done_q;

  logic [W-1:0]  pre_in, pre_out;
  logic [W-1:0]  rot_out;
  logic [Z-1:0]  e_sum;
  logic          sel_b;

  // one prefix unit serves both substitutions
  assign pre_in = (step_q == ST_FWD1) ? up_q : work_q;

  ldpc_prefix_xor #(.Z(Z), .NSEG(NSEG)) u_prefix (
    .vec_i (pre_in),
    .acc_o (pre_out)
  );

  // one rotator bank serves the E row and the B column
  assign sel_b = (step_q == ST_BMUL);

  for (genvar s = 0; s < NSEG; s++) begin : g_rot
    logic [Z-1:0]   r_in;
    logic [SHW-1:0] r_sh;
    assign r_in = sel_b ? ps_q : work_q[s*Z +: Z];
    assign r_sh = sel_b ? b_q[s*SHW +: SHW] : e_q[s*SHW +: SHW];
    ldpc_circ_rot #(.Z(Z), .SHW(SHW)) u_rot (
      .seg_i   (r_in),
      .shift_i (r_sh),
      .seg_o   (rot_out[s*Z +: Z])
    );
  end

  always_comb begin
    e_sum = '0;
    for (int s = 0; s < NSEG; s++) e_sum = e_sum ^ rot_out[s*Z +: Z];
  end

  always_comb begin
    case (step_q)
      ST_IDLE:  step_d = start_i ? ST_FWD1 : ST_IDLE;
      ST_FWD1:  step_d = ST_EMUL;
      ST_EMUL:  step_d = ST_SHORT;
      ST_SHORT: step_d = ST_BMUL;
      ST_BMUL:  step_d = ST_COMB;
      ST_COMB:  step_d = ST_FWD2;
      default:  step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= ST_IDLE;
      up_q      <= '0;
      low_q     <= '0;
      e_q       <= '0;
      b_q       <= '0;
      work_q    <= '0;
      ps_q      <= '0;
      p_short_q <= '0;
      p_long_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == ST_FWD2);
      case (step_q)
        ST_IDLE: if (start_i) begin
          up_q  <= up_prod_i;
          low_q <= low_prod_i;
          e_q   <= e_shift_i;
          b_q   <= b_shift_i;
        end
        ST_FWD1:  work_q <= pre_out;           // f3
        ST_EMUL:  ps_q   <= e_sum;             // f4
        ST_SHORT: ps_q   <= ps_q ^ low_q;      // short parity, correction is identity
        ST_BMUL:  work_q <= rot_out;           // f5
        ST_COMB:  work_q <= work_q ^ up_q;     // f6
        ST_FWD2: begin
          p_long_q  <= pre_out;
          p_short_q <= ps_q;
        end
        default: ;
      endcase
    end
  end

  assign p_short_o = p_short_q;
  assign p_long_o  = p_long_q;
  assign done_o    = done_q;
endmodule

// File: rtl/ldpc_gap_solver_chk.sv
module ldpc_gap_solver_chk
  import ldpc_gap_pkg::*;
#(
  parameter int unsigned Z    = 64,
  parameter int unsigned NSEG = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [Z-1:0]      p_short_o,
  input logic [NSEG*Z-1:0] p_long_o,
  input logic [NSEG*Z-1:0] f6_i
);
  localparam int unsigned CW = $clog2(STEP_COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(STEP_COUNT);

  logic [CW-1:0] cnt;

  // independent schedule tracker; starts seen mid-frame are dropped (R9)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= '0;
    else if (cnt == '0)    cnt <= start_i ? CW'(1) : '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end

  assert_done_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == LAST) |=> done_o);

  assert_no_stray_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != LAST) |=> !done_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(p_long_o) && $stable(p_short_o)));

  assert_fwd_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (p_long_o[Z-1:0] == f6_i[Z-1:0]));

  for (genvar s = 1; s < NSEG; s++) begin : g_fwd
    assert_fwd_sub_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ((p_long_o[s*Z +: Z] ^ p_long_o[(s-1)*Z +: Z]) == f6_i[s*Z +: Z]));
  end
endmodule

bind ldpc_gap_solver ldpc_gap_solver_chk #(.Z(Z), .NSEG(NSEG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .p_short_o (p_short_o),
  .p_long_o  (p_long_o),
  .f6_i      (work_q)
);

// File: tb/ldpc_gap_solver_test.sv
module ldpc_gap_solver_test;
  localparam int Z    = 64;
  localparam int NSEG = 7;
  localparam int SHW  = 7;
  localparam int W    = NSEG * Z;
  localparam int SW   = NSEG * SHW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  up_prod = '0;
  logic [Z-1:0]  low_prod = '0;
  logic [SW-1:0] e_sh = '0;
  logic [SW-1:0] b_sh = '0;
  logic [Z-1:0]  p_short;
  logic [W-1:0]  p_long;
  logic          done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string tag = "R3";

  always #4 clk = ~clk;

  ldpc_gap_solver #(.Z(Z), .NSEG(NSEG), .SHW(SHW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .up_prod_i(up_prod), .low_prod_i(low_prod),
    .e_shift_i(e_sh), .b_shift_i(b_sh),
    .p_short_o(p_short), .p_long_o(p_long), .done_o(done)
  );

  function automatic logic [Z-1:0] mrot(input logic [Z-1:0] x, input int q);
    logic [Z-1:0] r;
    r = '0;
    if (q >= Z) return r;
    for (int i = 0; i < Z; i++) r[i] = x[(i + q) % Z];
    return r;
  endfunction

  function automatic logic [Z-1:0] mshort(input logic [W-1:0] f1, input logic [Z-1:0] f2,
                                          input logic [SW-1:0] e);
    logic [Z-1:0] acc, s;
    acc = '0;
    s = f2;
    for (int j = 0; j < NSEG; j++) begin
      acc = acc ^ f1[j*Z +: Z];
      s = s ^ mrot(acc, int'(e[j*SHW +: SHW]));
    end
    return s;
  endfunction

  function automatic logic [W-1:0] mlong(input logic [W-1:0] f1, input logic [Z-1:0] ps,
                                         input logic [SW-1:0] b);
    logic [Z-1:0] acc;
    logic [W-1:0] r;
    acc = '0;
    r = '0;
    for (int i = 0; i < NSEG; i++) begin
      acc = acc ^ f1[i*Z +: Z] ^ mrot(ps, int'(b[i*SHW +: SHW]));
      r[i*Z +: Z] = acc;
    end
    return r;
  endfunction

  // upper check rows: T*p_long + B*p_short + A*u = 0
  function automatic bit rows_zero(input logic [W-1:0] f1, input logic [W-1:0] pl,
                                   input logic [Z-1:0] ps, input logic [SW-1:0] b);
    logic [Z-1:0] lhs;
    for (int i = 0; i < NSEG; i++) begin
      lhs = pl[i*Z +: Z] ^ mrot(ps, int'(b[i*SHW +: SHW]));
      if (i > 0) lhs = lhs ^ pl[(i-1)*Z +: Z];
      if (lhs != f1[i*Z +: Z]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // cycle model
  int            mcnt = 0;
  logic          m_done = 1'b0;
  logic [Z-1:0]  m_short = '0, pend_s = '0;
  logic [W-1:0]  m_long = '0, pend_l = '0;
  logic [W-1:0]  fr_f1 = '0;
  logic [SW-1:0] fr_b = '0;
  logic          prev_done = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= 0; m_done <= 1'b0; m_short <= '0; m_long <= '0;
    end else begin
      m_done <= 1'b0;
      if (mcnt == 0) begin
        if (start) begin
          mcnt   <= 1;
          pend_s <= mshort(up_prod, low_prod, e_sh);
          pend_l <= mlong(up_prod, mshort(up_prod, low_prod, e_sh), b_sh);
          fr_f1  <= up_prod;
          fr_b   <= b_sh;
        end
      end else if (mcnt == 6) begin
        mcnt <= 0; m_done <= 1'b1; m_short <= pend_s; m_long <= pend_l;
      end else begin
        mcnt <= mcnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done === m_done, "R6 done timing", W'(done), W'(m_done));
      chk(!(done && prev_done), "R7 done pulse", W'(done), W'(0));
      if (m_done) begin
        chk(p_short === m_short, {tag, " short parity"}, W'(p_short), W'(m_short));
        chk(p_long === m_long, {tag, " long parity"}, p_long, m_long);
        chk(rows_zero(fr_f1, p_long, p_short, fr_b), "R5 upper rows sum to zero", p_long, m_long);
      end else begin
        chk(p_short === m_short && p_long === m_long, "R8 hold", p_long, m_long);
      end
      prev_done <= done;
    end
  end

  function automatic logic [W-1:0] rnd_w();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [SW-1:0] rnd_sh();
    logic [SW-1:0] v;
    for (int i = 0; i < NSEG; i++)
      v[i*SHW +: SHW] = ($urandom_range(0, 3) == 0) ? 7'd127 : 7'($urandom_range(0, 63));
    return v;
  endfunction

  task automatic frame(input logic [W-1:0] f1, input logic [Z-1:0] f2,
                       input logic [SW-1:0] e, input logic [SW-1:0] b);
    @(negedge clk);
    up_prod = f1; low_prod = f2; e_sh = e; b_sh = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(p_short === '0 && p_long === '0 && done === 1'b0, "R10 reset", p_long, '0);

    // identity circulants everywhere
    tag = "R3";
    frame(rnd_w(), 64'h0123_4567_89ab_cdef, '0, '0);

    // all-zero blocks: short = lower product, long = running XOR of upper
    tag = "R2";
    frame(rnd_w(), 64'hdead_beef_0000_ffff, {NSEG{7'd127}}, {NSEG{7'd127}});
    // shift boundaries 63, 64, 100 mixed with 1
    frame(rnd_w(), 64'h1, {7'd63, 7'd64, 7'd100, 7'd1, 7'd63, 7'd0, 7'd64},
          {7'd1, 7'd63, 7'd64, 7'd127, 7'd0, 7'd63, 7'd2});

    // R9: second start mid-frame with other inputs is dropped
    tag = "R9";
    @(negedge clk);
    up_prod = rnd_w(); low_prod = 64'hffff; e_sh = rnd_sh(); b_sh = rnd_sh(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    up_prod = rnd_w(); low_prod = 64'h5555; e_sh = rnd_sh(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);

    // start held high: frames run back to back
    tag = "R4";
    @(negedge clk);
    up_prod = rnd_w(); low_prod = 64'hcafe; e_sh = rnd_sh(); b_sh = rnd_sh(); start = 1'b1;
    repeat (22) @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);

    // random frames over the R1 segment layout
    tag = "R1";
    for (int n = 0; n < 24; n++)
      frame(rnd_w(), {$urandom, $urandom}, rnd_sh(), rnd_sh());

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule